// File: doc/BRIEF.md
# Ascending Byte Stack Unit

This block holds the stack pointer of a small processor core and moves single bytes between the core and a stack kept in a 128-byte on-chip data RAM. The stack grows toward higher addresses: a push first raises the pointer and then stores the byte where the pointer now points, so the pointer always addresses the newest entry. A pop reads the entry under the pointer, hands it to the destination output, and only then lowers the pointer.

Each operation is timed as one machine cycle of twelve oscillator periods, where one period is one clock of `clk`. The core issues a push, a pop or a direct pointer load while the unit is idle. The unit then stays busy for twelve clocks and signals completion with a one-clock done pulse. A pointer value at or above the RAM size is allowed, because the pointer is a plain 8-bit register that wraps modulo 256. An operation that would touch such an address writes nothing and reports a range error instead. Status flags of the core are not part of this unit, and nothing here alters them.

Top module: `asc_stack`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the pointer reads 07H and busy, done and range_err are all low.
- R2: A push is accepted on a clock edge where busy is low and push_req is high. The pointer is raised by one at that same edge and reads old+1 in the next cycle, before any RAM write happens. After reset, the first push therefore targets address 08H.
- R3: A push stores the src_byte sampled at acceptance into RAM at the raised pointer. A push never reads the RAM.
- R4: A pop is accepted on an idle edge with pop_req high, provided push_req is low. When done rises, dst_byte holds the RAM byte at the pointer value from before the pop, and the pointer reads that value minus one.
- R5: After acceptance, busy is high for exactly 12 clocks. On the 12th clock, busy drops and done is high for one clock only.
- R6: The pointer wraps modulo 256. If the addressed location is 80H or above, a push writes nothing and a pop leaves dst_byte unchanged. In both cases range_err is high together with done, while the pointer still moves by one.
- R7: A pointer load is accepted on an idle edge with ld_req high and neither push_req nor pop_req high. It sets the pointer to the ld_val sampled at acceptance, in the cycle where done is high, and never raises range_err.
- R8: Any command presented while busy is high is ignored and raises no error. If push or pop coincides with a load on an idle edge, the load is dropped. Push takes priority over pop.
- R9: A push followed by a pop returns the pushed byte and restores the pointer to its value before the push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, one period per clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Request to push src_byte |
| pop_req | input | 1 | Request to pop into dst_byte |
| ld_req | input | 1 | Request to load the pointer with ld_val |
| src_byte | input | 8 | Byte to be pushed |
| ld_val | input | 8 | New pointer value for a load |
| busy | output | 1 | Machine cycle in progress |
| done | output | 1 | One-clock completion pulse |
| range_err | output | 1 | Addressed location lies outside the RAM, valid with done |
| dst_byte | output | 8 | Last byte returned by a successful pop |
| sp_out | output | 8 | Current stack pointer |

## Verification
The assertions assume that reset is held for at least one clock edge before any command. They also assume that the request inputs are settled at the clock edge, with no meaning given to their values while busy is high. The stimulus drives every input on the falling edge, raises a request for exactly one idle edge, and deliberately waves requests during busy cycles to confirm they are dropped. Random pointer loads, biased toward the RAM boundary and toward the 00H/FFH wrap, keep the out-of-range and wrap-around cases frequent. The data of a pop is compared only where the reference model knows the RAM contents.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_LOAD = 2'd2
  } stk_op_e;
endpackage

// File: rtl/stk_pacer.sv
module stk_pacer #(
  parameter int PERIODS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last,
  output logic [$clog2(PERIODS)-1:0] phase
);
  localparam int CW = $clog2(PERIODS);
  localparam logic [CW-1:0] LAST_PH = CW'(PERIODS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        phase <= '0;
      end
    end else if (phase == LAST_PH) begin
      busy  <= 1'b0;
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign last = busy && (phase == LAST_PH);
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int          SP_W     = 8,
  parameter logic [7:0]  RESET_SP = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  input  logic            dec,
  input  logic            load,
  input  logic [SP_W-1:0] load_val,
  output logic [SP_W-1:0] sp
);
  always_ff @(posedge clk) begin
    if (rst)       sp <= SP_W'(RESET_SP);
    else if (inc)  sp <= sp + 1'b1;
    else if (dec)  sp <= sp - 1'b1;
    else if (load) sp <= load_val;
  end
endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/asc_stack.sv
module asc_stack #(
  parameter int         DATA_W   = 8,
  parameter int         SP_W     = 8,
  parameter int         DEPTH    = 128,
  parameter int         PERIODS  = 12,
  parameter logic [7:0] RESET_SP = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic              ld_req,
  input  logic [DATA_W-1:0] src_byte,
  input  logic [SP_W-1:0]   ld_val,
  output logic              busy,
  output logic              done,
  output logic              range_err,
  output logic [DATA_W-1:0] dst_byte,
  output logic [SP_W-1:0]   sp_out
);
  import stk_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(PERIODS);
  localparam logic [CW-1:0] RD_PH = CW'(1);
  localparam logic [CW-1:0] WR_PH = CW'(PERIODS / 2);

  logic          start, last, in_range;
  logic [CW-1:0] phase;
  stk_op_e       op_sel, op_q;
  logic [DATA_W-1:0] src_q, rd_q;
  logic [SP_W-1:0]   ld_q;
  logic          ram_we, ram_re;

  assign start = !busy && (push_req || pop_req || ld_req);

  always_comb begin
    if (push_req)     op_sel = OP_PUSH;
    else if (pop_req) op_sel = OP_POP;
    else              op_sel = OP_LOAD;
  end

  stk_pacer #(.PERIODS(PERIODS)) u_pacer (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .last(last), .phase(phase)
  );

  stk_ptr #(.SP_W(SP_W), .RESET_SP(RESET_SP)) u_ptr (
    .clk(clk), .rst(rst),
    .inc(start && op_sel == OP_PUSH),
    .dec(last && op_q == OP_POP),
    .load(last && op_q == OP_LOAD),
    .load_val(ld_q),
    .sp(sp_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= OP_LOAD;
      src_q <= '0;
      ld_q  <= '0;
    end else if (start) begin
      op_q  <= op_sel;
      src_q <= src_byte;
      ld_q  <= ld_val;
    end
  end

  assign in_range = ({1'b0, sp_out} < (SP_W+1)'(DEPTH));
  assign ram_we   = busy && op_q == OP_PUSH && phase == WR_PH && in_range;
  assign ram_re   = busy && op_q == OP_POP  && phase == RD_PH && in_range;

  stk_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .re(ram_re),
    .addr(sp_out[AW-1:0]), .wdata(src_q), .rdata(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      range_err <= 1'b0;
      dst_byte  <= '0;
    end else begin
      done      <= last;
      range_err <= last && op_q != OP_LOAD && !in_range;
      if (last && op_q == OP_POP && in_range) dst_byte <= rd_q;
    end
  end
endmodule

// File: rtl/asc_stack_chk.sv
module asc_stack_chk #(
  parameter int SP_W  = 8,
  parameter int DEPTH = 128
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            done,
  input logic            range_err,
  input logic [SP_W-1:0] sp_out,
  input logic            wr_en,
  input logic            rd_en
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (sp_out == 8'h07 && !busy && !done && !range_err));

  assert_no_read_on_push_R3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));

  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_busy_fall_done_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_write_in_ram_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ({1'b0, sp_out} < (SP_W+1)'(DEPTH)));

  assert_err_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    range_err |-> done);

  assert_sp_held_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(sp_out));
endmodule

bind asc_stack asc_stack_chk #(.SP_W(SP_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .range_err(range_err),
  .sp_out(sp_out), .wr_en(ram_we), .rd_en(ram_re)
);

// File: tb/asc_stack_bench.sv
module asc_stack_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_req = 1'b0, pop_req = 1'b0, ld_req = 1'b0;
  logic [7:0] src_byte = '0, ld_val = '0;
  logic busy, done, range_err;
  logic [7:0] dst_byte, sp_out;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  logic [7:0] mmem [128];
  bit         mval [128];
  logic [7:0] msp;
  logic [7:0] mdst;
  bit         mdst_ok;

  always #10 clk = ~clk;

  asc_stack u_asc_stack (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .ld_req(ld_req), .src_byte(src_byte), .ld_val(ld_val),
    .busy(busy), .done(done), .range_err(range_err),
    .dst_byte(dst_byte), .sp_out(sp_out)
  );

  function automatic bit in_ram(input logic [7:0] a);
    return a < 8'h80;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // wait through busy; optionally wave ignored requests (R8)
  task automatic wait_cycle(input bit noise);
    for (int i = 0; i < 11; i++) begin
      if (noise) begin
        push_req = $urandom_range(0, 1);
        pop_req  = $urandom_range(0, 1);
        ld_req   = $urandom_range(0, 1);
        src_byte = $urandom;
        ld_val   = $urandom;
      end
      @(negedge clk);
    end
    push_req = 0; pop_req = 0; ld_req = 0;
    @(negedge clk);
  endtask

  task automatic do_push(input logic [7:0] d, input bit noise, input bit with_ld);
    logic [7:0] nsp;
    bit err;
    nsp = msp + 8'd1;
    err = !in_ram(nsp);
    push_req = 1; src_byte = d; ld_req = with_ld; ld_val = 8'h33;
    @(negedge clk);
    push_req = 0; ld_req = 0;
    check(busy === 1'b1, "R5 busy after push accept", busy, 1);
    check(sp_out === nsp, "R2 pointer raised before write", sp_out, nsp);
    wait_cycle(noise);
    check(done === 1'b1 && busy === 1'b0, "R5 push done pulse", {busy, done}, 1);
    check(range_err === err, "R6 push range flag", range_err, err);
    check(sp_out === nsp, with_ld ? "R8 coincident load dropped" : "R2 push pointer", sp_out, nsp);
    msp = nsp;
    if (!err) begin mmem[nsp[6:0]] = d; mval[nsp[6:0]] = 1; end
  endtask

  task automatic do_pop(input bit noise);
    logic [7:0] osp;
    bit err;
    osp = msp;
    err = !in_ram(osp);
    pop_req = 1;
    @(negedge clk);
    pop_req = 0;
    check(busy === 1'b1, "R5 busy after pop accept", busy, 1);
    wait_cycle(noise);
    check(done === 1'b1 && busy === 1'b0, "R5 pop done pulse", {busy, done}, 1);
    check(range_err === err, "R6 pop range flag", range_err, err);
    check(sp_out === osp - 8'd1, "R4 pointer lowered after pop", sp_out, osp - 8'd1);
    if (err) begin
      if (mdst_ok) check(dst_byte === mdst, "R6 dst unchanged out of range", dst_byte, mdst);
    end else if (mval[osp[6:0]]) begin
      check(dst_byte === mmem[osp[6:0]], "R4 popped byte", dst_byte, mmem[osp[6:0]]);
      mdst = mmem[osp[6:0]]; mdst_ok = 1;
    end else begin
      mdst_ok = 0;
    end
    msp = osp - 8'd1;
  endtask

  task automatic do_load(input logic [7:0] v, input bit noise);
    ld_req = 1; ld_val = v;
    @(negedge clk);
    ld_req = 0;
    check(busy === 1'b1, "R7 busy after load accept", busy, 1);
    wait_cycle(noise);
    check(done === 1'b1 && range_err === 1'b0, "R7 load done no error", {done, range_err}, 2);
    check(sp_out === v, "R7 loaded pointer", sp_out, v);
    msp = v;
  endtask

  initial begin
    #(200000 * 20);
    miscompares++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 128; i++) mval[i] = 0;
    msp = 8'h07; mdst = 8'h00; mdst_ok = 1;
    repeat (3) @(negedge clk);
    check(sp_out === 8'h07, "R1 reset pointer", sp_out, 8'h07);
    rst = 0;
    @(negedge clk);
    check(sp_out === 8'h07 && !busy && !done && !range_err, "R1 state after reset",
          {busy, done, range_err}, 0);

    // R2 first push lands at 08H, R9 push-pop round trip
    do_push(8'hA5, 0, 0);
    check(sp_out === 8'h08, "R2 first push at 08H", sp_out, 8'h08);
    do_pop(0);
    check(dst_byte === 8'hA5 && sp_out === 8'h07, "R9 round trip", dst_byte, 8'hA5);

    // R8 ignored commands during busy, push beats coincident load
    do_push(8'h3C, 1, 1);
    do_pop(1);
    check(dst_byte === 8'h3C, "R9 round trip with noise", dst_byte, 8'h3C);

    // R6 top of RAM boundary
    do_load(8'h7E, 0);
    do_push(8'h11, 0, 0);
    do_push(8'h22, 0, 0);
    do_pop(0);
    do_pop(0);
    check(dst_byte === 8'h11, "R6 byte at 7FH survives", dst_byte, 8'h11);

    // R6 wrap 00H -> FFH -> 00H
    do_load(8'h00, 0);
    do_push(8'h5A, 0, 0);
    do_load(8'h00, 0);
    do_pop(0);
    check(sp_out === 8'hFF, "R6 wrap below zero", sp_out, 8'hFF);
    do_pop(0);
    do_push(8'h66, 0, 0);
    do_push(8'h77, 0, 0);
    do_pop(0);
    check(dst_byte === 8'h77, "R6 wrap push at 00H", dst_byte, 8'h77);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 45)      do_push(8'($urandom), $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0);
      else if (r < 88) do_pop($urandom_range(0, 3) == 0);
      else begin
        int k;
        k = $urandom_range(0, 3);
        if (k == 0)      do_load(8'($urandom_range(8'h78, 8'h85)), 0);
        else if (k == 1) do_load(8'($urandom_range(0, 3)), 0);
        else if (k == 2) do_load(8'($urandom_range(8'hFC, 8'hFF)), 0);
        else             do_load(8'($urandom_range(8'h08, 8'h70)), 0);
      end
    end

    summary();
  end
endmodule